// File: doc/BRIEF.md
# Dual-Path Predicated Fetch Sequencer

This block produces the fetch address for a core that predicates hard-to-predict branches while the program runs. In its normal state it follows the predictor on a single path: each cycle it fetches from one program counter and loads the predicted next address into it. When the instruction being fetched is a branch that the compiler flagged as a diverge branch, and the confidence estimator marks it as low confidence, the block splits into two paths. One path is the fall-through (not-taken) path and the other is the taken path. Each path has its own program counter and its own global history register.

While both paths are live, fetch slots alternate between them. A path retires when its predicted next address equals the merge-point address that arrived with the diverge branch. After that, every slot goes to the surviving path. Once both paths have retired, single-path fetch resumes at the merge point.

Each fetch carries three tags for the later register-merge stage:
- a path bit,
- a predicate tag allocated when the dual-path episode began,
- a flag that records whether the episode was opened by a loop branch.

A pipeline redirect overrides everything in the cycle it arrives.

Top module: `dpf_ctrl`

## Requirements
- R1: After reset `fetch_pc` equals the parameter `RESET_PC`. `fetch_dual`, `fetch_path`, `fetch_pred_id`, `fetch_loop` and `fetch_ghr` are all zero.
- R2: In single-path mode the next `fetch_pc` is `pred_next_pc`. When `br_valid` is high, the history shifts left by one and takes `pred_taken` into bit 0.
- R3: Dual-path mode begins on the next cycle only if all of the following hold: the block is in single-path mode, `br_valid`, `br_diverge` and `br_lowconf` are high, and `redirect_valid` is low. The not-taken path (path bit 0) starts at `fetch_pc + INSTR_BYTES` with the old history shifted in a 0. The taken path (path bit 1) starts at `br_target` with a 1 shifted in.
- R4: While both paths are live, fetch alternates between them on consecutive cycles. The first slot after entry goes to path 0.
- R5: In dual-path mode, when the active path's `pred_next_pc` equals the merge address latched at entry, that path stops. All later slots go to the other path.
- R6: When the last live path reaches the merge address, `fetch_dual` drops on the next cycle and `fetch_pc` equals the latched merge address, on path 0.
- R7: A diverge branch fetched during dual-path mode opens no new episode. It is handled as an ordinary branch of the active path, and the predicate tag stays unchanged.
- R8: `redirect_valid` takes priority over all other inputs. On the next cycle `fetch_dual` is 0, `fetch_path` is 0 and `fetch_pc` equals `redirect_pc`.
- R9: Each dual-path entry advances a predicate counter by one, modulo 2^`PRED_W`, starting from 0 after reset. `fetch_pred_id` shows the counter value only while `fetch_dual` is 1 and is 0 otherwise. `fetch_loop` shows the `br_loop` value captured at entry while `fetch_dual` is 1.
- R10: A start address that already equals `br_merge` gives a path that is never live. If only one path is live, every dual-path slot goes to it. If neither is live, no episode starts and the next `fetch_pc` is `br_merge`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redirect_valid | input | 1 | Pipeline redirect request |
| redirect_pc | input | AW | Redirect target |
| br_valid | input | 1 | Current fetch is a conditional branch |
| br_diverge | input | 1 | Branch carries the diverge flag |
| br_loop | input | 1 | Branch carries the loop flag |
| br_lowconf | input | 1 | Confidence estimator reports low confidence |
| br_target | input | AW | Taken target of the current branch |
| br_merge | input | AW | Merge-point address of the current diverge branch |
| pred_next_pc | input | AW | Predicted next address for the current fetch |
| pred_taken | input | 1 | Predicted direction of the current branch |
| fetch_pc | output | AW | Address fetched this cycle |
| fetch_path | output | 1 | 0 = not-taken/primary path, 1 = taken path |
| fetch_dual | output | 1 | Dual-path mode active |
| fetch_pred_id | output | PRED_W | Predicate tag of the current episode |
| fetch_loop | output | 1 | Current episode was opened by a loop branch |
| fetch_ghr | output | HW | History of the active path, for the predictor |

## Verification
The bench builds the block with AW=16, HW=8, INSTR_BYTES=4 and PRED_W=2. The two-bit predicate tag lets four back-to-back episodes wrap the tag back to zero within a short run. The eight-bit history is wide enough that the separate 0 and 1 pushes of the two paths show up as distinct values. The sixteen-bit addresses keep the merge and fall-through collisions, used for single-live and no-entry episodes, easy to place.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic {
    PATH_NT = 1'b0,
    PATH_TK = 1'b1
  } path_e;
endpackage

// File: rtl/dpf_path_slot.sv
module dpf_path_slot #(
  parameter int AW = 16,
  parameter int HW = 8,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          force_ld,
  input  logic [AW-1:0] force_pc,
  input  logic          start,
  input  logic [AW-1:0] start_pc,
  input  logic [HW-1:0] start_hist,
  input  logic          start_live,
  input  logic          step,
  input  logic [AW-1:0] step_pc,
  input  logic          cmp_en,
  input  logic [AW-1:0] merge_pc,
  input  logic          hist_en,
  input  logic          hist_bit,
  output logic [AW-1:0] pc_q,
  output logic [HW-1:0] hist_q,
  output logic          live_q,
  output logic          reach
);
  function automatic logic [HW-1:0] hist_push(input logic [HW-1:0] h, input logic b);
    return {h[HW-2:0], b};
  endfunction

  assign reach = step && cmp_en && live_q && (step_pc == merge_pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      hist_q <= '0;
      live_q <= 1'b0;
    end else begin
      if (force_ld)          pc_q <= force_pc;
      else if (start)        pc_q <= start_pc;
      else if (step && !reach) pc_q <= step_pc;

      if (start)                hist_q <= start_hist;
      else if (step && hist_en) hist_q <= hist_push(hist_q, hist_bit);

      if (clear)      live_q <= 1'b0;
      else if (start) live_q <= start_live;
      else if (reach) live_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dpf_turn_arb.sv
module dpf_turn_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dual,
  input  logic [1:0] live,
  input  logic       enter,
  output logic       sel
);
  logic turn_q;

  function automatic logic pick_path(input logic d, input logic [1:0] lv, input logic t);
    if (!d) return 1'b0;
    if (lv == 2'b11) return t;
    return lv[1];
  endfunction

  assign sel = pick_path(dual, live, turn_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     turn_q <= 1'b0;
    else if (enter) turn_q <= 1'b0;
    else if (dual)  turn_q <= ~sel;
  end
endmodule

// File: rtl/dpf_mode_ctl.sv
module dpf_mode_ctl #(
  parameter int AW = 16,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          converge,
  input  logic          redirect,
  input  logic [AW-1:0] merge_in,
  input  logic          loop_in,
  output logic          dual_q,
  output logic [AW-1:0] merge_q,
  output logic [PW-1:0] pid_q,
  output logic          loop_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q  <= 1'b0;
      merge_q <= '0;
      pid_q   <= '0;
      loop_q  <= 1'b0;
    end else begin
      if (redirect)      dual_q <= 1'b0;
      else if (enter)    dual_q <= 1'b1;
      else if (converge) dual_q <= 1'b0;
      if (enter) begin
        merge_q <= merge_in;
        pid_q   <= pid_q + 1'b1;
        loop_q  <= loop_in;
      end
    end
  end
endmodule

// File: rtl/dpf_ctrl.sv
module dpf_ctrl #(
  parameter int AW = 16,
  parameter int HW = 8,
  parameter int PRED_W = 3,
  parameter int INSTR_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [AW-1:0]     redirect_pc,
  input  logic              br_valid,
  input  logic              br_diverge,
  input  logic              br_loop,
  input  logic              br_lowconf,
  input  logic [AW-1:0]     br_target,
  input  logic [AW-1:0]     br_merge,
  input  logic [AW-1:0]     pred_next_pc,
  input  logic              pred_taken,
  output logic [AW-1:0]     fetch_pc,
  output logic              fetch_path,
  output logic              fetch_dual,
  output logic [PRED_W-1:0] fetch_pred_id,
  output logic              fetch_loop,
  output logic [HW-1:0]     fetch_ghr
);
  import dpf_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

  logic              dual_q, loop_q, sel;
  logic [AW-1:0]     merge_q;
  logic [PRED_W-1:0] pid_q;
  logic [AW-1:0]     pc_v   [2];
  logic [HW-1:0]     hist_v [2];
  logic [1:0]        live_v, reach_v, step_v;
  logic [AW-1:0]     fall_pc, force0_pc;
  logic              div_cond, nt_live, tk_live;
  logic              enter_ev, skip_ev, retire_ev, converge_ev, force0;
  logic              other_live;
  logic [AW-1:0]     start_pc_v [2];
  logic [HW-1:0]     start_hist_v [2];
  logic [1:0]        start_live_v;

  assign fetch_pc      = pc_v[sel];
  assign fetch_ghr     = hist_v[sel];
  assign fetch_path    = sel;
  assign fetch_dual    = dual_q;
  assign fetch_pred_id = dual_q ? pid_q : '0;
  assign fetch_loop    = dual_q & loop_q;

  assign fall_pc  = fetch_pc + STEP;
  assign nt_live  = (fall_pc != br_merge);
  assign tk_live  = (br_target != br_merge);
  assign div_cond = !dual_q && br_valid && br_diverge && br_lowconf && !redirect_valid;
  assign enter_ev = div_cond && (nt_live || tk_live);
  assign skip_ev  = div_cond && !nt_live && !tk_live;

  assign retire_ev   = |reach_v;
  assign other_live  = sel ? live_v[0] : live_v[1];
  assign converge_ev = dual_q && retire_ev && !other_live;

  assign force0    = redirect_valid || converge_ev || skip_ev;
  assign force0_pc = redirect_valid ? redirect_pc :
                     converge_ev    ? merge_q     : br_merge;

  assign step_v[0] = dual_q ? (sel == PATH_NT) : 1'b1;
  assign step_v[1] = dual_q && (sel == PATH_TK);

  assign start_pc_v[0]   = fall_pc;
  assign start_pc_v[1]   = br_target;
  assign start_hist_v[0] = {fetch_ghr[HW-2:0], 1'b0};
  assign start_hist_v[1] = {fetch_ghr[HW-2:0], 1'b1};
  assign start_live_v    = {tk_live, nt_live};

  for (genvar g = 0; g < 2; g++) begin : g_path
    dpf_path_slot #(.AW(AW), .HW(HW), .RESET_PC(RESET_PC)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (redirect_valid),
      .force_ld   ((g == 0) ? force0 : 1'b0),
      .force_pc   (force0_pc),
      .start      (enter_ev),
      .start_pc   (start_pc_v[g]),
      .start_hist (start_hist_v[g]),
      .start_live (start_live_v[g]),
      .step       (step_v[g]),
      .step_pc    (pred_next_pc),
      .cmp_en     (dual_q),
      .merge_pc   (merge_q),
      .hist_en    (br_valid),
      .hist_bit   (pred_taken),
      .pc_q       (pc_v[g]),
      .hist_q     (hist_v[g]),
      .live_q     (live_v[g]),
      .reach      (reach_v[g])
    );
  end

  dpf_turn_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .dual  (dual_q),
    .live  (live_v),
    .enter (enter_ev),
    .sel   (sel)
  );

  dpf_mode_ctl #(.AW(AW), .PW(PRED_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (enter_ev),
    .converge (converge_ev),
    .redirect (redirect_valid),
    .merge_in (br_merge),
    .loop_in  (br_loop),
    .dual_q   (dual_q),
    .merge_q  (merge_q),
    .pid_q    (pid_q),
    .loop_q   (loop_q)
  );
endmodule

// File: rtl/dpf_ctrl_chk.sv
module dpf_ctrl_chk #(
  parameter int AW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic          br_valid,
  input logic          br_diverge,
  input logic          br_lowconf,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_path,
  input logic          fetch_dual,
  input logic [PW-1:0] fetch_pred_id,
  input logic [1:0]    live_v,
  input logic [AW-1:0] merge_q
);
  assert_entry_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_dual) |-> $past(br_valid && br_diverge && br_lowconf && !redirect_valid));

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_dual && live_v == 2'b11 && $past(fetch_dual) && $past(live_v) == 2'b11)
      |-> fetch_path != $past(fetch_path));

  assert_single_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_dual && $countones(live_v) == 1) |-> live_v[fetch_path]);

  assert_exit_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fetch_dual) && !$past(redirect_valid)) |-> (fetch_pc == merge_q && !fetch_path));

  assert_tag_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_dual && $past(fetch_dual) && !$past(redirect_valid)) |-> $stable(fetch_pred_id));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redirect_valid) |-> (!fetch_dual && !fetch_path && fetch_pc == $past(redirect_pc)));
endmodule

bind dpf_ctrl dpf_ctrl_chk #(.AW(AW), .PW(PRED_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .br_valid       (br_valid),
  .br_diverge     (br_diverge),
  .br_lowconf     (br_lowconf),
  .fetch_pc       (fetch_pc),
  .fetch_path     (fetch_path),
  .fetch_dual     (fetch_dual),
  .fetch_pred_id  (fetch_pred_id),
  .live_v         (live_v),
  .merge_q        (merge_q)
);

// File: tb/dpf_ctrl_bench.sv
module dpf_ctrl_bench;
  localparam int AW = 16;
  localparam int HW = 8;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          redirect_valid = 0, br_valid = 0, br_diverge = 0, br_loop = 0, br_lowconf = 0, pred_taken = 0;
  logic [AW-1:0] redirect_pc = 0, br_target = 0, br_merge = 0, pred_next_pc = 0;
  logic [AW-1:0] fetch_pc;
  logic          fetch_path, fetch_dual, fetch_loop;
  logic [PW-1:0] fetch_pred_id;
  logic [HW-1:0] fetch_ghr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dpf_ctrl #(.AW(AW), .HW(HW), .PRED_W(PW), .INSTR_BYTES(4), .RESET_PC(16'h0000)) u_dpf_ctrl (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .br_valid(br_valid), .br_diverge(br_diverge), .br_loop(br_loop), .br_lowconf(br_lowconf),
    .br_target(br_target), .br_merge(br_merge), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
    .fetch_pc(fetch_pc), .fetch_path(fetch_path), .fetch_dual(fetch_dual),
    .fetch_pred_id(fetch_pred_id), .fetch_loop(fetch_loop), .fetch_ghr(fetch_ghr));

  typedef struct packed {
    logic        redir;
    logic [15:0] rpc;
    logic        brv;
    logic        div;
    logic        lowc;
    logic [15:0] tgt;
    logic [15:0] mrg;
    logic [15:0] nxt;
    logic [15:0] exp_pc;
    logic        exp_path;
    logic        exp_dual;
    logic [1:0]  exp_pid;
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{1'b1, 16'h0040, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0,   16'h0000, 1'b0, 1'b0, 2'd0}, // R1 reset, R8 redirect
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0044, 16'h0040, 1'b0, 1'b0, 2'd0}, // R8 target, R2
    '{1'b0, 16'h0,    1'b1, 1'b1, 1'b1, 16'h0080, 16'h0100, 16'h0080, 16'h0044, 1'b0, 1'b0, 2'd0}, // R3 entry
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h004C, 16'h0048, 1'b0, 1'b1, 2'd1}, // R3 R4 R9
    '{1'b0, 16'h0,    1'b1, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0084, 16'h0080, 1'b1, 1'b1, 2'd1}, // R4
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0100, 16'h004C, 1'b0, 1'b1, 2'd1}, // R5 path0 retires
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0088, 16'h0084, 1'b1, 1'b1, 2'd1}, // R5
    '{1'b0, 16'h0,    1'b1, 1'b1, 1'b1, 16'h0200, 16'h0100, 16'h0100, 16'h0088, 1'b1, 1'b1, 2'd1}, // R5 R7 nested
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0104, 16'h0100, 1'b0, 1'b0, 2'd0}, // R6 exit
    '{1'b0, 16'h0,    1'b1, 1'b1, 1'b0, 16'h0300, 16'h0400, 16'h0300, 16'h0104, 1'b0, 1'b0, 2'd0}, // R2 high conf
    '{1'b0, 16'h0,    1'b1, 1'b1, 1'b1, 16'h0400, 16'h0500, 16'h0400, 16'h0300, 1'b0, 1'b0, 2'd0}, // R3 second entry
    '{1'b1, 16'h0600, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0308, 16'h0304, 1'b0, 1'b1, 2'd2}, // R9 R8
    '{1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 16'h0, 16'h0,   16'h0604, 16'h0600, 1'b0, 1'b0, 2'd0}  // R8 cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    redirect_valid = 0; br_valid = 0; br_diverge = 0; br_loop = 0; br_lowconf = 0;
    pred_taken = 0; redirect_pc = 0; br_target = 0; br_merge = 0; pred_next_pc = 0;
  endtask

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #5 rst_n = 1;
    #2;
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 ghr", 32'(fetch_ghr), 0);
    chk("R1 loop", 32'(fetch_loop), 0);
    for (int i = 0; i < 13; i++) begin
      chk($sformatf("R-table row %0d pc", i), 32'(fetch_pc), 32'(TBL[i].exp_pc));
      chk($sformatf("R-table row %0d path/dual/pid", i),
          {28'd0, fetch_path, fetch_dual, fetch_pred_id},
          {28'd0, TBL[i].exp_path, TBL[i].exp_dual, TBL[i].exp_pid});
      redirect_valid = TBL[i].redir; redirect_pc = TBL[i].rpc;
      br_valid = TBL[i].brv; br_diverge = TBL[i].div; br_lowconf = TBL[i].lowc;
      br_target = TBL[i].tgt; br_merge = TBL[i].mrg; pred_next_pc = TBL[i].nxt;
      pred_taken = TBL[i].tgt == TBL[i].nxt && TBL[i].brv;
      tick();
    end

    // R2 history, R3 split histories, R9 loop flag
    do_reset();
    br_valid = 1; pred_taken = 1; pred_next_pc = 16'h0010;
    tick(); idle_in();
    chk("R2 ghr shift", 32'(fetch_ghr), 32'h01);
    chk("R2 pc", 32'(fetch_pc), 32'h0010);
    br_valid = 1; br_diverge = 1; br_lowconf = 1; br_loop = 1;
    br_target = 16'h0020; br_merge = 16'h0100; pred_next_pc = 16'h0020;
    tick(); idle_in(); pred_next_pc = 16'h0018;
    chk("R3 nt pc", 32'(fetch_pc), 32'h0014);
    chk("R3 nt ghr", 32'(fetch_ghr), 32'h02);
    chk("R9 loop tag", 32'(fetch_loop), 1);
    tick(); idle_in();
    chk("R3 tk path", 32'(fetch_path), 1);
    chk("R3 tk ghr", 32'(fetch_ghr), 32'h03);
    chk("R3 tk pc", 32'(fetch_pc), 32'h0020);

    // R10 both starts on merge: no entry
    redirect_valid = 1; redirect_pc = 16'h0030;
    tick(); idle_in();
    br_valid = 1; br_diverge = 1; br_lowconf = 1; br_target = 16'h0034; br_merge = 16'h0034;
    pred_next_pc = 16'h0034;
    tick(); idle_in();
    chk("R10 no entry dual", 32'(fetch_dual), 0);
    chk("R10 no entry pc", 32'(fetch_pc), 32'h0034);
    // R10 only taken path live
    br_valid = 1; br_diverge = 1; br_lowconf = 1; br_target = 16'h0050; br_merge = 16'h0038;
    pred_next_pc = 16'h0050;
    tick(); idle_in(); pred_next_pc = 16'h0054;
    chk("R10 single live", {31'd0, fetch_dual}, 1);
    chk("R10 taken pc", {fetch_path, 15'd0, fetch_pc}, {1'b1, 15'd0, 16'h0050});
    tick(); idle_in();
    chk("R10 taken again", {fetch_path, 15'd0, fetch_pc}, {1'b1, 15'd0, 16'h0054});

    // R9 predicate tag wraps modulo 4
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      br_valid = 1; br_diverge = 1; br_lowconf = 1; br_target = 16'h0700; br_merge = 16'h0800;
      tick(); idle_in();
      chk($sformatf("R9 tag episode %0d", k), {30'd0, fetch_pred_id}, 32'(k % 4));
      redirect_valid = 1; redirect_pc = 16'h0000;
      tick(); idle_in();
      chk("R9 tag zero outside", {30'd0, fetch_pred_id}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule